// File: doc/BRIEF.md
# PMIC Bring-up Configuration Sequencer

This block runs on the host side of a power-management device. It brings the device out of reset and loads its configuration. It drives the device's reset pin and a group of output-enable pins, and it watches the device's active-low interrupt line. All register traffic goes through a generic command port that uses a request/acknowledge handshake. A separate bus master, outside this block, carries each command to the device.

After power-up, the sequencer:

1. waits for the supply-good indication;
2. releases the reset pin;
3. waits for the device to pull its interrupt line low, which is its signal that it is ready for traffic;
4. reads the status register;
5. writes a parameter table of configuration registers, with the voltage setting as entry 0;
6. writes all ones to the interrupt register to clear every pending flag;
7. raises the enables.

After that it sits in a finished state. A later falling edge on the interrupt line means a register-reset or similar event, and the sequencer runs again from the interrupt-wait step.

Top module: `pmic_bringup_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the reset pin drive, all enables, the command request, done and the timeout flag are low.
- R2: The reset pin drive stays low while supply-good is low. It goes high within 5 cycles of supply-good going high and stays high afterwards. No command is requested while the reset pin drive is low.
- R3: After the reset pin is released, no command is requested until the interrupt input has been seen low.
- R4: The first command of every run is a read of address STAT_ADDR. The returned data ANDed with STAT_MASK (default bit 0) being non-zero marks a register reset. Other returned bits are ignored.
- R5: Table entries are written in index order, with entry 0 (the voltage setting) first. Address and data of entry i come from slice i of WR_ADDRS and WR_DATAS. Command fields hold steady until the acknowledge.
- R6: After the last table entry, one write of all-ones data goes to CLR_ADDR. That write completes before any enable is raised on the first run.
- R7: When the clear write is acknowledged, every enable goes high and done asserts in the same cycle.
- R8: While done is high, a falling edge on the interrupt input drops done within 6 cycles. The run then restarts, beginning with the status read.
- R9: In a re-run, a status read that shows the register-reset flag drives all enables low until the clear write completes. A status read without the flag leaves the enables high for the whole run.
- R10: If the interrupt input stays high for TIMEOUT_CYC cycles after the reset pin is released, the timeout flag rises and stays high until reset. A later low interrupt still lets the sequence complete.
- R11: The request drops in the cycle after the acknowledge. At most one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above undervoltage level (asynchronous, synchronised inside) |
| irq_n_i | input | 1 | Device interrupt line, active low (asynchronous) |
| rst_pin_o | output | 1 | Device reset drive, high releases the device |
| en_o | output | EN_W | Output-enable drives, high enables |
| cmd_req_o | output | 1 | Command request |
| cmd_rd_o | output | 1 | Command is a read when high, a write when low |
| cmd_addr_o | output | ADDR_W | Register address |
| cmd_wdata_o | output | DATA_W | Write data |
| cmd_ack_i | input | 1 | Command acknowledge, one-cycle pulse |
| cmd_rdata_i | input | DATA_W | Read data, valid with the acknowledge |
| done_o | output | 1 | Configuration complete and outputs enabled |
| timeout_err_o | output | 1 | Sticky interrupt-wait timeout flag |

## Verification
The bench models the device as a responder. Each stage of the run uses a different combination of acknowledge latency (0 to 3 cycles) and re-run cause (register-reset flag set or clear). Three kinds of fault are exposed this way:

- A sequencer that starts bus traffic on a timer, or before the interrupt goes low, shows requests during the silent window after release.
- One that misorders the table or skips the clear write produces a wrong command log.
- One that enables outputs before clearing interrupts is seen with enables high at the clear write.

Re-runs with the flag absent catch a design that always drops the enables. Re-runs with the flag present catch one that never does. A design that reacts to the interrupt level instead of its edge would loop after the clear write and never settle in done. The timeout run checks that the flag stays quiet ten cycles before the limit, is set ten cycles after it, and survives the later completion.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_IRQ  = 3'd1,
    ST_STAT = 3'd2,
    ST_CFG  = 3'd3,
    ST_CLR  = 3'd4,
    ST_DONE = 3'd5
  } seq_st_t;
endpackage

// File: rtl/pmic_irq_timer.sv
module pmic_irq_timer #(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired_o = run_i && (cnt == LIMIT);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT) else $error("timer count beyond limit");
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt == '0) else $error("timer not cleared when idle");
endmodule

// File: rtl/pmic_cmd_table.sv
module pmic_cmd_table #(
  parameter int NUM_WR = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter logic [NUM_WR*ADDR_W-1:0] WR_ADDRS = '0,
  parameter logic [NUM_WR*DATA_W-1:0] WR_DATAS = '0
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] a_arr [NUM_WR];
  logic [DATA_W-1:0] d_arr [NUM_WR];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_ent
    assign a_arr[g] = WR_ADDRS[g*ADDR_W +: ADDR_W];
    assign d_arr[g] = WR_DATAS[g*DATA_W +: DATA_W];
  end

  assign addr_o = a_arr[idx_i];
  assign data_o = d_arr[idx_i];
endmodule

// File: rtl/pmic_bringup_seq.sv
module pmic_bringup_seq
  import pmic_seq_pkg::*;
#(
  parameter int EN_W        = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_WR      = 4,
  parameter int TIMEOUT_CYC = 500000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h18,
  parameter logic [DATA_W-1:0] STAT_MASK = 8'h01,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h19,
  parameter logic [NUM_WR*ADDR_W-1:0] WR_ADDRS = {8'h23, 8'h22, 8'h21, 8'h20},
  parameter logic [NUM_WR*DATA_W-1:0] WR_DATAS = {8'hD4, 8'hC3, 8'hB2, 8'hA1}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok_i,
  input  logic              irq_n_i,
  output logic              rst_pin_o,
  output logic [EN_W-1:0]   en_o,
  output logic              cmd_req_o,
  output logic              cmd_rd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              cmd_ack_i,
  input  logic [DATA_W-1:0] cmd_rdata_i,
  output logic              done_o,
  output logic              timeout_err_o
);
  localparam int IDX_W = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WR - 1);

  seq_st_t st;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        sup_sync;
  logic [2:0]        irq_sync;
  logic              supply_seen, irq_low, irq_fall;
  logic              tmr_expired;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DATA_W-1:0] tbl_data;
  logic              reg_reset_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_sync <= '0;
      irq_sync <= '1;
    end else begin
      sup_sync <= {sup_sync[0], supply_ok_i};
      irq_sync <= {irq_sync[1:0], irq_n_i};
    end
  end

  assign supply_seen    = sup_sync[1];
  assign irq_low        = !irq_sync[1];
  assign irq_fall       = irq_sync[2] && !irq_sync[1];
  assign reg_reset_seen = |(cmd_rdata_i & STAT_MASK);

  pmic_irq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .run_i    (st == ST_IRQ),
    .expired_o(tmr_expired)
  );

  pmic_cmd_table #(
    .NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .WR_ADDRS(WR_ADDRS), .WR_DATAS(WR_DATAS)
  ) u_tbl (
    .idx_i (idx),
    .addr_o(tbl_addr),
    .data_o(tbl_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_PWR;
      rst_pin_o     <= 1'b0;
      en_o          <= '0;
      cmd_req_o     <= 1'b0;
      cmd_rd_o      <= 1'b0;
      cmd_addr_o    <= '0;
      cmd_wdata_o   <= '0;
      idx           <= '0;
      done_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      case (st)
        ST_PWR: begin
          if (supply_seen) begin
            rst_pin_o <= 1'b1;
            st        <= ST_IRQ;
          end
        end
        ST_IRQ: begin
          if (irq_low) st <= ST_STAT;
          else if (tmr_expired) timeout_err_o <= 1'b1;
        end
        ST_STAT: begin
          if (!cmd_req_o) begin
            cmd_req_o   <= 1'b1;
            cmd_rd_o    <= 1'b1;
            cmd_addr_o  <= STAT_ADDR;
            cmd_wdata_o <= '0;
          end else if (cmd_ack_i) begin
            cmd_req_o <= 1'b0;
            cmd_rd_o  <= 1'b0;
            if (reg_reset_seen) en_o <= '0;
            idx <= '0;
            st  <= ST_CFG;
          end
        end
        ST_CFG: begin
          if (!cmd_req_o) begin
            cmd_req_o   <= 1'b1;
            cmd_rd_o    <= 1'b0;
            cmd_addr_o  <= tbl_addr;
            cmd_wdata_o <= tbl_data;
          end else if (cmd_ack_i) begin
            cmd_req_o <= 1'b0;
            if (idx == LAST_IDX) st <= ST_CLR;
            else idx <= idx + 1'b1;
          end
        end
        ST_CLR: begin
          if (!cmd_req_o) begin
            cmd_req_o   <= 1'b1;
            cmd_rd_o    <= 1'b0;
            cmd_addr_o  <= CLR_ADDR;
            cmd_wdata_o <= '1;
          end else if (cmd_ack_i) begin
            cmd_req_o <= 1'b0;
            en_o      <= '1;
            done_o    <= 1'b1;
            st        <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (irq_fall) begin
            done_o <= 1'b0;
            st     <= ST_IRQ;
          end
        end
        default: st <= ST_PWR;
      endcase
    end
  end

  p_hold_fields_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o && $stable(cmd_addr_o)
      && $stable(cmd_wdata_o) && $stable(cmd_rd_o))
    else $error("command changed before acknowledge");
  p_drop_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_req_o && cmd_ack_i |=> !cmd_req_o)
    else $error("request held after acknowledge");
  p_no_cmd_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_req_o |-> rst_pin_o)
    else $error("command while device held in reset");
  p_release_stays_r2: assert property (@(posedge clk) disable iff (rst)
    rst_pin_o |=> rst_pin_o)
    else $error("reset pin dropped after release");
  p_done_en_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> en_o == '1)
    else $error("done without all enables");
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    timeout_err_o |=> timeout_err_o)
    else $error("timeout flag cleared");
endmodule

// File: tb/pmic_bringup_seq_test.sv
module pmic_bringup_seq_test;
  localparam int EN_W = 3;
  localparam int NUM_WR = 4;
  localparam int TMO = 60;
  localparam logic [7:0] STAT = 8'h18;
  localparam logic [7:0] CLR  = 8'h19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic irq_n = 1'b1;
  logic cmd_ack = 1'b0;
  logic [7:0] cmd_rdata = 8'h00;
  logic rst_pin, cmd_req, cmd_rd, done, terr;
  logic [EN_W-1:0] en;
  logic [7:0] cmd_addr, cmd_wdata;

  int checks = 0;
  int errors = 0;
  int ack_dly = 1;
  bit dev_flag = 1'b0;
  bit finished = 1'b0;
  int log_n = 0;
  bit log_rd [16];
  logic [7:0] log_addr [16];
  logic [7:0] log_data [16];
  logic [EN_W-1:0] log_en [16];

  always #2 clk = ~clk;

  pmic_bringup_seq #(
    .EN_W(EN_W), .NUM_WR(NUM_WR), .TIMEOUT_CYC(TMO),
    .STAT_ADDR(STAT), .STAT_MASK(8'h01), .CLR_ADDR(CLR),
    .WR_ADDRS({8'h23, 8'h22, 8'h21, 8'h20}),
    .WR_DATAS({8'hD4, 8'hC3, 8'hB2, 8'hA1})
  ) uut (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .irq_n_i(irq_n),
    .rst_pin_o(rst_pin), .en_o(en), .cmd_req_o(cmd_req), .cmd_rd_o(cmd_rd),
    .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata), .cmd_ack_i(cmd_ack),
    .cmd_rdata_i(cmd_rdata), .done_o(done), .timeout_err_o(terr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // device responder
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_req) begin
        logic [7:0] a0, d0;
        bit r0;
        a0 = cmd_addr; d0 = cmd_wdata; r0 = cmd_rd;
        repeat (ack_dly) @(negedge clk);
        chk(cmd_addr == a0 && cmd_wdata == d0 && cmd_rd == r0, "R5 stable",
            {cmd_addr, cmd_wdata}, {a0, d0});
        if (log_n < 16) begin
          log_rd[log_n] = cmd_rd; log_addr[log_n] = cmd_addr;
          log_data[log_n] = cmd_wdata; log_en[log_n] = en;
          log_n++;
        end
        if (cmd_rd) cmd_rdata = dev_flag ? 8'h41 : 8'h40;
        else if (cmd_addr == CLR && cmd_wdata[0]) begin
          dev_flag = 1'b0;
          irq_n = 1'b1;
        end
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        chk(!cmd_req, "R11", cmd_req, 0);
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_log(input bit exp_en_high, input string tag);
    chk(log_n == NUM_WR + 2, {tag, " count"}, log_n, NUM_WR + 2);
    chk(log_rd[0] && log_addr[0] == STAT, "R4 status read first", log_addr[0], STAT);
    for (int i = 0; i < NUM_WR; i++) begin
      logic [7:0] ea, ed;
      ea = 8'h20 + 8'(i);
      ed = 8'hA1 + 8'(8'h11 * i);
      chk(!log_rd[i+1] && log_addr[i+1] == ea && log_data[i+1] == ed,
          "R5 table order", {log_addr[i+1], log_data[i+1]}, {ea, ed});
    end
    chk(!log_rd[NUM_WR+1] && log_addr[NUM_WR+1] == CLR && log_data[NUM_WR+1] == 8'hFF,
        "R6 clear write", {log_addr[NUM_WR+1], log_data[NUM_WR+1]}, {CLR, 8'hFF});
    for (int i = 1; i < NUM_WR + 2; i++)
      chk(log_en[i] == (exp_en_high ? '1 : '0), "R9 R6 enables during run",
          log_en[i], exp_en_high ? 7 : 0);
    chk(en == '1 && done, "R7 enables at done", en, 7);
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit ok, seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rst_pin && en == 0 && !cmd_req && !done && !terr, "R1 reset state",
        {rst_pin, en, cmd_req, done, terr}, 0);
    ok = 1'b1;
    repeat (15) begin @(negedge clk); if (rst_pin) ok = 1'b0; end
    chk(ok, "R2 held without supply", rst_pin, 0);
    supply_ok = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (rst_pin) seen = 1'b1; end
    chk(seen, "R2 release after supply", rst_pin, 1);
    dev_flag = 1'b1;
    ok = 1'b1;
    repeat (30) begin @(negedge clk); if (cmd_req || terr) ok = 1'b0; end
    chk(ok, "R3 silent before interrupt", cmd_req, 0);
    log_n = 0;
    irq_n = 1'b0;
    wait_done(ok);
    chk(ok, "R7 first run done", done, 1);
    check_log(1'b0, "R5 first run");
    chk(!terr, "R10 no timeout", terr, 0);

    for (int d = 0; d < 4; d++) begin
      for (int f = 0; f < 2; f++) begin
        ack_dly = d;
        repeat (5) @(negedge clk);
        log_n = 0;
        dev_flag = f[0];
        irq_n = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (!done) seen = 1'b1; end
        chk(seen, "R8 done drops on event", done, 0);
        wait_done(ok);
        chk(ok, "R8 rerun completes", done, 1);
        check_log(f == 0, "R8 rerun");
      end
    end

    rst = 1'b1;
    irq_n = 1'b1;
    ack_dly = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (rst_pin) begin seen = 1'b1; break; end end
    chk(seen, "R2 release again", rst_pin, 1);
    repeat (TMO - 10) @(negedge clk);
    chk(!terr, "R10 before limit", terr, 0);
    repeat (20) @(negedge clk);
    chk(terr, "R10 after limit", terr, 1);
    log_n = 0;
    dev_flag = 1'b1;
    irq_n = 1'b0;
    wait_done(ok);
    chk(ok && terr, "R10 completes with flag kept", {done, terr}, 3);
    summary();
  end
endmodule